// File: doc/BRIEF.md
# Trapped Memory-Access Instruction Transformer

This block takes a memory-access instruction that has just raised a trap and produces the 32-bit transformed encoding that a trap handler reads back from the trap-instruction register. A compressed load or store is rewritten into its full-width equivalent. In the rewritten form, the immediate fields are cleared to zero. The rs1 field then carries the byte offset of the faulting address inside the naturally aligned access window. That offset is zero for an aligned access.

The trap logic raises `req_valid` for one cycle and presents the trapping instruction, the faulting address and the current register width. In that same cycle the block decodes the base register and drives its index on `rf_raddr`. A register-file read port returns the base register's contents on `rf_rdata` combinationally. On the next clock edge the block registers the result, and `tinst_valid` is high for one cycle.

A two-state controller sequences the output. `ST_IDLE` means no result is pending, and `ST_SHOW` means the result register holds a fresh value. The `GO_SHOW` transition is taken on any clock edge where `req_valid` is high, from either state. The `GO_IDLE` transition is taken from `ST_SHOW` when no new request arrives. While no request is present, the controller stays in `ST_IDLE`.

Top module: `tinst_xform`

## Requirements
- R1: An instruction whose bits [1:0] are not 2'b11 is compressed. A compressed instruction in quadrant 1 (bits [1:0]=01), or with a funct3 (bits [15:13]) other than 1, 2, 3, 5, 6 or 7 in quadrants 0 and 2, yields a result of 32'h0.
- R2: In quadrant 0, the base register is x(8+bits[9:7]), and this index is driven on `rf_raddr` in the request cycle. The data register is x(8+bits[4:2]). For loads (funct3 1, 2, 3) it goes into result bits [11:7]. For stores (funct3 5, 6, 7) it goes into bits [24:20].
- R3: In quadrant 2, the base register is x2. A load takes its rd from bits [11:7] and a store takes its rs2 from bits [6:2]. Both are placed as in R2.
- R4: funct3=1 expands to FLD (opcode 0000111, width code 3). funct3=2 expands to LW (0000011, code 2). funct3=5 expands to FSD (0100111, code 3). funct3=6 expands to SW (0100011, code 2). funct3=3 expands to FLW when `xlen64`=0 and to LD when `xlen64`=1. funct3=7 expands to FSW or SD in the same way. Word forms access 4 bytes and double forms access 8. The width code goes in result bits [14:12].
- R5: Every result produced from a compressed instruction has bit 1 cleared.
- R6: A full-width load (opcode 0000011) or FP load (0000111) keeps bits [19:0] apart from the offset field, and has bits [31:20] zeroed. Its access size is 1<<funct3.
- R7: A full-width store (opcode 0100011) or FP store (0100111) has bits [11:7] and [31:25] zeroed. Its access size is 1<<funct3.
- R8: An atomic instruction (opcode 0101111) passes through with only the offset field rewritten. Its access size is 1<<funct3 and its immediate is zero.
- R9: A SYSTEM instruction (opcode 1110011) with funct3=4 passes through with only the offset field rewritten. Its access size is 1<<bits[27:26] and its immediate is zero. Any other SYSTEM instruction, or any other full-width opcode, yields 32'h0.
- R10: When the access size is nonzero, result bits [19:15] hold the low 5 bits of (fault address − (base value + sign-extended immediate)) AND (size − 1).
- R11: After reset, `tinst_valid`=0 and `tinst`=0. A request in cycle n gives `tinst_valid`=1 and the result in cycle n+1. `tinst_valid` is 0 in any cycle that follows a cycle without a request, and `tinst` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transform request strobe |
| req_insn | input | 32 | Trapping instruction (compressed forms use bits [15:0]) |
| req_addr | input | DW | Faulting virtual address |
| xlen64 | input | 1 | 1 selects 64-bit register width, 0 selects 32-bit |
| rf_raddr | output | 5 | Base register index for the register-file read port |
| rf_rdata | input | DW | Base register value returned by the read port |
| tinst_valid | output | 1 | Result valid, one cycle after the request |
| tinst | output | 32 | Transformed instruction |

## Verification
The block is driven with directed instructions in both quadrants that are expanded and in the quadrant that is not. The immediate patterns in these cases make each bit-scrambled offset field distinct, so a swapped immediate bit shows up as a wrong offset. Each width-dependent funct3 is applied with both `xlen64` values, which separates the FLW/LD and FSW/SD mappings. Faulting addresses are placed exactly on the computed address and then a few bytes past it, so that aligned results with a zero offset can be told apart from misaligned ones. After that come several hundred random instructions across every decoded opcode, each with a random fault address. These are compared every clock against a behavioural model, including cycles without a request, where `tinst_valid` must be low.

// File: rtl/tinst_pkg.sv
package tinst_pkg;

    localparam logic [6:0] OPC_LOAD    = 7'b0000011;
    localparam logic [6:0] OPC_FLOAD   = 7'b0000111;
    localparam logic [6:0] OPC_STORE   = 7'b0100011;
    localparam logic [6:0] OPC_FSTORE  = 7'b0100111;
    localparam logic [6:0] OPC_AMO     = 7'b0101111;
    localparam logic [6:0] OPC_SYSTEM  = 7'b1110011;

    localparam int IMM_W  = 13;
    localparam int REG_W  = 5;

    typedef enum logic {
        ST_IDLE,
        ST_SHOW
    } ctl_state_e;

    typedef struct packed {
        logic [31:0]       tmpl;
        logic [REG_W-1:0]  base;
        logic [IMM_W-1:0]  imm;
        logic [2:0]        size_lg2;
        logic              has_acc;
    } xf_dec_t;

    function automatic logic [31:0] build_ld(input logic [6:0] opc, input logic [2:0] wc,
                                             input logic [4:0] rd);
        return {12'b0, 5'b0, wc, rd, opc};
    endfunction

    function automatic logic [31:0] build_st(input logic [6:0] opc, input logic [2:0] wc,
                                             input logic [4:0] rs2);
        return {7'b0, rs2, 5'b0, wc, 5'b0, opc};
    endfunction

endpackage

// File: rtl/tinst_cdec.sv
module tinst_cdec
    import tinst_pkg::*;
(
    input  logic [15:0] insn,
    input  logic        xlen64,
    output xf_dec_t     dec
);
    logic [1:0]  quad;
    logic [2:0]  f3;
    logic [4:0]  reg_q0_data;
    logic [4:0]  reg_q0_base;
    logic [4:0]  reg_data;
    logic [4:0]  reg_base;
    logic [8:0]  off_w;
    logic [8:0]  off_d;

    assign quad        = insn[1:0];
    assign f3          = insn[15:13];
    assign reg_q0_data = {2'b01, insn[4:2]};
    assign reg_q0_base = {2'b01, insn[9:7]};

    // immediate selection: word / double, register-relative / stack-relative
    always_comb begin
        if (quad == 2'b00) begin
            off_w = {2'b0, insn[5], insn[12:10], insn[6], 2'b00};
            off_d = {1'b0, insn[6:5], insn[12:10], 3'b000};
        end else if (f3 >= 3'd5) begin
            off_w = {1'b0, insn[8:7], insn[12:9], 2'b00};
            off_d = {insn[9:7], insn[12:10], 3'b000};
        end else begin
            off_w = {1'b0, insn[3:2], insn[12], insn[6:4], 2'b00};
            off_d = {insn[4:2], insn[12], insn[6:5], 3'b000};
        end
    end

    always_comb begin
        if (quad == 2'b00) begin
            reg_data = reg_q0_data;
            reg_base = reg_q0_base;
        end else begin
            reg_data = (f3 >= 3'd5) ? insn[6:2] : insn[11:7];
            reg_base = 5'd2;
        end
    end

    always_comb begin
        dec          = '0;
        dec.base     = reg_base;
        if (quad == 2'b00 || quad == 2'b10) begin
            unique case (f3)
                3'd1: begin
                    dec.tmpl = build_ld(OPC_FLOAD, 3'd3, reg_data);
                    dec.imm  = {4'b0, off_d};
                    dec.size_lg2 = 3'd3;
                    dec.has_acc  = 1'b1;
                end
                3'd2: begin
                    dec.tmpl = build_ld(OPC_LOAD, 3'd2, reg_data);
                    dec.imm  = {4'b0, off_w};
                    dec.size_lg2 = 3'd2;
                    dec.has_acc  = 1'b1;
                end
                3'd3: begin
                    if (xlen64) begin
                        dec.tmpl = build_ld(OPC_LOAD, 3'd3, reg_data);
                        dec.imm  = {4'b0, off_d};
                        dec.size_lg2 = 3'd3;
                    end else begin
                        dec.tmpl = build_ld(OPC_FLOAD, 3'd2, reg_data);
                        dec.imm  = {4'b0, off_w};
                        dec.size_lg2 = 3'd2;
                    end
                    dec.has_acc = 1'b1;
                end
                3'd5: begin
                    dec.tmpl = build_st(OPC_FSTORE, 3'd3, reg_data);
                    dec.imm  = {4'b0, off_d};
                    dec.size_lg2 = 3'd3;
                    dec.has_acc  = 1'b1;
                end
                3'd6: begin
                    dec.tmpl = build_st(OPC_STORE, 3'd2, reg_data);
                    dec.imm  = {4'b0, off_w};
                    dec.size_lg2 = 3'd2;
                    dec.has_acc  = 1'b1;
                end
                3'd7: begin
                    if (xlen64) begin
                        dec.tmpl = build_st(OPC_STORE, 3'd3, reg_data);
                        dec.imm  = {4'b0, off_d};
                        dec.size_lg2 = 3'd3;
                    end else begin
                        dec.tmpl = build_st(OPC_FSTORE, 3'd2, reg_data);
                        dec.imm  = {4'b0, off_w};
                        dec.size_lg2 = 3'd2;
                    end
                    dec.has_acc = 1'b1;
                end
                default: begin
                    dec.tmpl    = '0;
                    dec.has_acc = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/tinst_wdec.sv
module tinst_wdec
    import tinst_pkg::*;
(
    input  logic [31:0] insn,
    output xf_dec_t     dec
);
    logic [6:0] opc;
    logic [2:0] f3;

    assign opc = insn[6:0];
    assign f3  = insn[14:12];

    always_comb begin
        dec      = '0;
        dec.base = insn[19:15];
        unique case (opc)
            OPC_LOAD, OPC_FLOAD: begin
                dec.tmpl     = {12'b0, insn[19:0]};
                dec.imm      = {insn[31], insn[31:20]};
                dec.size_lg2 = f3;
                dec.has_acc  = 1'b1;
            end
            OPC_STORE, OPC_FSTORE: begin
                dec.tmpl     = {7'b0, insn[24:12], 5'b0, insn[6:0]};
                dec.imm      = {insn[31], insn[31:25], insn[11:7]};
                dec.size_lg2 = f3;
                dec.has_acc  = 1'b1;
            end
            OPC_AMO: begin
                dec.tmpl     = insn;
                dec.size_lg2 = f3;
                dec.has_acc  = 1'b1;
            end
            OPC_SYSTEM: begin
                if (f3 == 3'd4) begin
                    dec.tmpl     = insn;
                    dec.size_lg2 = {1'b0, insn[27:26]};
                    dec.has_acc  = 1'b1;
                end
            end
            default: begin
                dec.tmpl    = '0;
                dec.has_acc = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tinst_ofs.sv
module tinst_ofs
    import tinst_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0]    fault_addr,
    input  logic [DW-1:0]    base_val,
    input  logic [IMM_W-1:0] imm,
    input  logic [2:0]       size_lg2,
    output logic [4:0]       ofs_field
);
    localparam int MW = 8;

    logic [DW-1:0] eff;
    logic [DW-1:0] diff;
    logic [MW-1:0] mask;
    logic [MW-1:0] masked;

    assign eff    = base_val + {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
    assign diff   = fault_addr - eff;
    assign mask   = (MW'(1) << size_lg2) - MW'(1);
    assign masked = diff[MW-1:0] & mask;
    assign ofs_field = masked[4:0];

endmodule

// File: rtl/tinst_xform.sv
module tinst_xform
    import tinst_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [31:0]   req_insn,
    input  logic [DW-1:0] req_addr,
    input  logic          xlen64,
    output logic [4:0]    rf_raddr,
    input  logic [DW-1:0] rf_rdata,
    output logic          tinst_valid,
    output logic [31:0]   tinst
);
    ctl_state_e state_q, state_d;
    xf_dec_t    dec_c, dec_w, dec_sel;
    logic       is_comp;
    logic [4:0] ofs_field;
    logic [31:0] result;
    logic [31:0] tinst_q;

    assign is_comp = (req_insn[1:0] != 2'b11);

    tinst_cdec u_cdec (
        .insn   (req_insn[15:0]),
        .xlen64 (xlen64),
        .dec    (dec_c)
    );

    tinst_wdec u_wdec (
        .insn (req_insn),
        .dec  (dec_w)
    );

    assign dec_sel  = is_comp ? dec_c : dec_w;
    assign rf_raddr = dec_sel.base;

    tinst_ofs #(.DW(DW)) u_ofs (
        .fault_addr (req_addr),
        .base_val   (rf_rdata),
        .imm        (dec_sel.imm),
        .size_lg2   (dec_sel.size_lg2),
        .ofs_field  (ofs_field)
    );

    always_comb begin
        result = dec_sel.tmpl;
        if (dec_sel.has_acc) begin
            result[19:15] = ofs_field;
        end
        if (is_comp) begin
            result[1] = 1'b0;
        end
    end

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = req_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // controller: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tinst_q <= '0;
        end else if (req_valid) begin
            tinst_q <= result;
        end
    end

    assign tinst_valid = (state_q == ST_SHOW);
    assign tinst       = tinst_q;

    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> tinst_valid);

    a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!tinst_valid && $stable(tinst)));

    a_r5_bit1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_comp) |=> !tinst[1]);

    a_r1_quad1_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_insn[1:0] == 2'b01) |=> (tinst == 32'h0));

    a_r3_sp_base: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_insn[1:0] == 2'b10 && dec_c.has_acc) |-> (rf_raddr == 5'd2));

    a_r2_q0_base: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_insn[1:0] == 2'b00 && dec_c.has_acc) |-> (rf_raddr[4:3] == 2'b01));

    a_r6_load_imm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_comp && (req_insn[6:0] == OPC_LOAD || req_insn[6:0] == OPC_FLOAD))
        |=> (tinst[31:20] == 12'h0));

    a_r7_store_imm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_comp && (req_insn[6:0] == OPC_STORE || req_insn[6:0] == OPC_FSTORE))
        |=> (tinst[31:25] == 7'h0 && tinst[11:7] == 5'h0));

endmodule

// File: tb/test_tinst_xform.sv
`timescale 1ns/1ps
module test_tinst_xform;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_insn = '0;
    logic [DW-1:0] req_addr = '0;
    logic          xlen64 = 1'b0;
    logic [4:0]    rf_raddr;
    logic [DW-1:0] rf_rdata;
    logic          tinst_valid;
    logic [31:0]   tinst;

    int n_vec = 0;
    int n_bad = 0;
    logic [63:0] regs [32];

    always #10 clk = ~clk;

    assign rf_rdata = regs[rf_raddr];

    tinst_xform #(.DW(DW)) i_tinst_xform (
        .clk, .rst_n, .req_valid, .req_insn, .req_addr, .xlen64,
        .rf_raddr, .rf_rdata, .tinst_valid, .tinst
    );

    // behavioural reference: returns expected result, base index and access size
    function automatic logic [31:0] ref_tinst(input logic [31:0] ins, input logic [63:0] fa,
                                              input logic rv64, output logic [4:0] bidx,
                                              output int sz);
        logic [31:0] t;
        longint      imm;
        int          f, dreg, opc, wcode;
        bit          st, fp;
        logic [63:0] d;
        t = 0; imm = 0; sz = 0; bidx = 0; st = 0; fp = 0; dreg = 0; opc = 0; wcode = 0;
        if (ins[1:0] != 2'b11) begin
            f = int'(ins[15:13]);
            if ((ins[1:0] == 2'b00 || ins[1:0] == 2'b10) &&
                (f == 1 || f == 2 || f == 3 || f == 5 || f == 6 || f == 7)) begin
                st = (f >= 5);
                case (f)
                    1, 5: begin fp = 1; sz = 8; end
                    2, 6: begin fp = 0; sz = 4; end
                    default: begin fp = !rv64; sz = rv64 ? 8 : 4; end
                endcase
                if (ins[1:0] == 2'b00) begin
                    bidx = 5'(8 + int'(ins[9:7]));
                    dreg = 8 + int'(ins[4:2]);
                    if (sz == 4) imm = ins[6]*4 + ins[12:10]*8 + ins[5]*64;
                    else         imm = ins[12:10]*8 + ins[6:5]*64;
                end else begin
                    bidx = 5'd2;
                    dreg = st ? int'(ins[6:2]) : int'(ins[11:7]);
                    if (!st && sz == 4) imm = ins[6:4]*4 + ins[12]*32 + ins[3:2]*64;
                    if (!st && sz == 8) imm = ins[6:5]*8 + ins[12]*32 + ins[4:2]*64;
                    if (st && sz == 4)  imm = ins[12:9]*4 + ins[8:7]*64;
                    if (st && sz == 8)  imm = ins[12:10]*8 + ins[9:7]*64;
                end
                opc   = st ? (fp ? 'h27 : 'h23) : (fp ? 'h07 : 'h03);
                wcode = (sz == 8) ? 3 : 2;
                if (st) t = 32'(dreg << 20) | 32'(wcode << 12) | 32'(opc);
                else    t = 32'(dreg << 7)  | 32'(wcode << 12) | 32'(opc);
            end
        end else begin
            bidx = ins[19:15];
            case (ins[6:0])
                7'h03, 7'h07: begin
                    t = ins & 32'h000F_FFFF;
                    imm = longint'($signed(ins[31:20]));
                    sz = 1 << ins[14:12];
                end
                7'h23, 7'h27: begin
                    t = ins & ~32'hFE00_0F80;
                    imm = longint'($signed({ins[31:25], ins[11:7]}));
                    sz = 1 << ins[14:12];
                end
                7'h2F: begin t = ins; sz = 1 << ins[14:12]; end
                7'h73: if (ins[14:12] == 3'd4) begin t = ins; sz = 1 << ins[27:26]; end
                default: t = 0;
            endcase
        end
        if (sz != 0) begin
            d = fa - regs[bidx] - 64'(imm);
            t[19:15] = 5'(d & 64'(sz - 1));
        end
        if (ins[1:0] != 2'b11) t[1] = 1'b0;
        return t;
    endfunction

    // reference pipeline and per-clock compare
    logic        exp_v = 1'b0;
    logic [31:0] exp_t = '0;

    always @(posedge clk) begin
        logic [4:0] bi; int sz; logic [31:0] tmp;
        if (!rst_n) begin
            exp_v <= 1'b0;
        end else begin
            exp_v <= req_valid;
            if (req_valid) begin
                tmp = ref_tinst(req_insn, req_addr, xlen64, bi, sz);
                exp_t <= tmp;
            end
        end
    end

    always @(negedge clk) begin
        logic [4:0] bi; int sz; logic [31:0] tmp;
        if (rst_n) begin
            n_vec++;
            if (tinst_valid !== exp_v) begin
                n_bad++;
                $display("FAIL R11 valid: got %0b expected %0b", tinst_valid, exp_v);
            end else if (exp_v && tinst !== exp_t) begin
                n_bad++;
                $display("FAIL R1-style result (R2 R3 R4 R6 R7 R8 R9 R10) insn-result got %08h expected %08h",
                         tinst, exp_t);
            end
            if (req_valid) begin
                tmp = ref_tinst(req_insn, req_addr, xlen64, bi, sz);
                if (sz != 0 && rf_raddr !== bi) begin
                    n_bad++;
                    $display("FAIL R2/R3 base index got %0d expected %0d", rf_raddr, bi);
                end
            end
        end
    end

    task automatic send(input logic [31:0] ins, input logic [63:0] fa, input logic rv);
        @(posedge clk); #5;
        req_valid = 1'b1; req_insn = ins; req_addr = fa; xlen64 = rv;
    endtask

    task automatic idle();
        @(posedge clk); #5;
        req_valid = 1'b0;
    endtask

    task automatic check_lit(input logic [31:0] want, input string tag);
        n_vec++;
        if (tinst !== want || tinst_valid !== 1'b1) begin
            n_bad++;
            $display("FAIL %s: got %08h/%0b expected %08h/1", tag, tinst, tinst_valid, want);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL R11 watchdog expired: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] ins;
        for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
        regs[10] = 64'h0000_0000_8000_1000;
        regs[2]  = 64'h0000_0000_0000_7F00;
        regs[5]  = 64'h0000_0000_0000_2000;
        repeat (3) @(negedge clk);
        n_vec++;
        if (tinst_valid !== 1'b0 || tinst !== 32'h0) begin
            n_bad++;
            $display("FAIL R11 reset state: got %0b/%08h expected 0/00000000", tinst_valid, tinst);
        end
        rst_n = 1'b1;

        // R2 R4 R5 R10: C.LW x9,4(x10), misaligned by 2
        send(32'h0000_4144, 64'h8000_1006, 1'b0);
        @(posedge clk); @(negedge clk);
        check_lit(32'h0001_2481, "R2 R10 c.lw misaligned");
        // same, aligned: offset 0
        send(32'h0000_4144, 64'h8000_1004, 1'b1);
        @(posedge clk); @(negedge clk);
        check_lit(32'h0000_2481, "R10 c.lw aligned");
        // R1: quadrant 1 gives zero
        send(32'h0000_4145, 64'h1, 1'b1);
        @(posedge clk); @(negedge clk);
        check_lit(32'h0, "R1 quadrant1");
        // R6: LW x1, -4(x5) at 0x1FFD -> offset 1, imm cleared
        send(32'hFFC2_A083, 64'h1FFD, 1'b1);
        @(posedge clk); @(negedge clk);
        check_lit(32'h0000_A083, "R6 load offset");
        // R7: SD x6, 8(x5) at 0x200B -> offset 3
        send(32'h0062_B423, 64'h200B, 1'b1);
        @(posedge clk); @(negedge clk);
        check_lit(32'h0061_B023, "R7 store offset");
        // R9: non-HLV system gives zero
        send(32'h0000_0073, 64'h0, 1'b1);
        @(posedge clk); @(negedge clk);
        check_lit(32'h0, "R9 other system");
        idle(); idle();

        // R3 R4: each width-dependent funct3 in both register widths, stack forms
        for (int rv = 0; rv < 2; rv++) begin
            for (int f = 0; f < 8; f++) begin
                send({16'h0, 3'(f), 13'b1_0101_0110_1010}, regs[2] + 64'(f * 3), 1'(rv));
                send({16'h0, 3'(f), 13'b0_1011_0011_0100}, regs[8 + (f % 8)] + 64'(f), 1'(rv));
            end
        end
        idle();

        // random sweep across every decoded class (R1-R10 each covered)
        for (int k = 0; k < 600; k++) begin
            int cls;
            cls = $urandom_range(0, 7);
            ins = $urandom;
            case (cls)
                0: ins = {16'h0, ins[15:2], 2'b00};
                1: ins = {16'h0, ins[15:2], 2'b10};
                2: ins = {16'h0, ins[15:2], 2'b01};
                3: ins[6:0] = ($urandom_range(0, 1) != 0) ? 7'h03 : 7'h07;
                4: ins[6:0] = ($urandom_range(0, 1) != 0) ? 7'h23 : 7'h27;
                5: ins[6:0] = 7'h2F;
                6: begin ins[6:0] = 7'h73; if ($urandom_range(0, 2) != 0) ins[14:12] = 3'd4; end
                default: ins[6:0] = 7'h33;
            endcase
            send(ins, {$urandom, $urandom}, 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 4) == 0) idle();
        end
        idle(); idle(); idle();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule